// File: doc/BRIEF.md
# Dual-channel regulator power-up sequencer

This block is the digital controller of a two-output linear regulator. It watches two per-channel enable requests and a synchronised undervoltage status. It then walks the shared analog circuitry through its start-up in a fixed order: trim capture, bandgap, reference and current generation, and bypass-capacitor precharge. Each stage is started by a one-cycle strobe and finishes when its done flag comes back. When the shared stages are ready, the block drives one enable per output channel.

Channel 1 has priority. Channel 2 may begin its ramp only when channel 1 is not requested, or when channel 1 is on and reports that it has reached its target. Once channel 2 is ramping, a late channel 1 request is served at once. If the input supply drops, both outputs go off and the whole sequence runs again after the supply recovers. If a stage never answers, a bounded wait raises a sticky fault and sends the block back to shutdown.

Top module: `pwrseq_dual`

## Requirements
- R1: After reset, and one cycle after both enables are seen low, all four stage strobes and both channel enables are 0.
- R2: After an enable rises, the trim strobe is not issued while the synchronised supply status is low. A change on `uv_ok_i` reaches the outputs in the third clock edge after it is applied, through two synchroniser flops and the state register.
- R3: The stage strobes fire in the order trim, bandgap, reference, bypass. Each strobe is high for exactly the first cycle of its stage, and at most one strobe is high at a time. A stage moves on at the edge after its done input is sampled high. The channel enables can only rise once the bypass stage has completed.
- R4: In the running state, `ch1_on_o` follows `ch1_en_i` with one cycle of latency. Channel 2 may start only when `ch1_en_i` is low, or when `ch1_on_o` and `ch1_at_target_i` are both high. Once started, channel 2 stays on for as long as `ch2_en_i` and the supply stay valid.
- R5: If both enables rise in the same cycle, channel 1 turns on first and channel 2 waits for channel 1 to reach its target. The same holds when channel 2 is requested first and channel 1 is requested before channel 2 has begun ramping.
- R6: If channel 1 is requested after channel 2 is already on, channel 1 turns on at the next edge without waiting.
- R7: A synchronised supply-low status turns off both channel enables at the next edge. When the supply recovers, the sequence restarts from the trim stage.
- R8: If a stage's done input stays low for `TMO_CYC` cycles, `fault_o` is set at that edge and all outputs go low. `fault_o` then stays set until reset. The block does not restart until both enables have been low at least once.
- R9: When one channel's enable falls, only that channel turns off. No stage strobe is issued while the other channel stays on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch1_en_i | input | 1 | Channel 1 enable request |
| ch2_en_i | input | 1 | Channel 2 enable request |
| uv_ok_i | input | 1 | Asynchronous supply status from the hysteretic undervoltage detector (1 = above threshold) |
| trim_done_i | input | 1 | Trim settings latched |
| bgap_done_i | input | 1 | Bandgap stable |
| ref_done_i | input | 1 | Reference and current generation stable |
| byp_done_i | input | 1 | Bypass capacitor charged |
| ch1_at_target_i | input | 1 | Channel 1 output has reached its target |
| trim_start_o | output | 1 | One-cycle strobe starting trim capture |
| bgap_start_o | output | 1 | One-cycle strobe starting the bandgap |
| ref_start_o | output | 1 | One-cycle strobe starting reference generation |
| byp_start_o | output | 1 | One-cycle strobe starting the bypass precharge |
| ch1_on_o | output | 1 | Channel 1 output enable |
| ch2_on_o | output | 1 | Channel 2 output enable |
| fault_o | output | 1 | Sticky stage-timeout fault |

## Verification
The enable patterns tried are: channel 1 alone, channel 2 alone, both in the same cycle, channel 2 first with channel 1 arriving during the shared stages, and channel 1 arriving after channel 2 is already on. These patterns separate a correct channel 1 priority from a design that always serialises or never serialises the two channels. The target flag of channel 1 is held low and then released, which shows whether channel 2 truly waits for it. Supply dropouts inside the running state, with recovery, check that both outputs fall together and that the trim stage is re-entered. A stage whose done input never rises checks the exact timeout edge, that the fault is sticky, and that a restart needs both enables to go low first.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    localparam int N_STAGE = 4;

    typedef enum logic [2:0] {
        PS_OFF,
        PS_WAIT_UV,
        PS_TRIM,
        PS_BGAP,
        PS_REF,
        PS_BYP,
        PS_RUN
    } pwr_state_e;

    typedef struct packed {
        pwr_state_e           state;
        logic [N_STAGE-1:0]   strobe;
        logic                 ch1_on;
        logic                 ch2_on;
        logic                 fault;
        logic                 blocked;
    } seq_regs_t;

    function automatic pwr_state_e stage_of(input int idx);
        case (idx)
            0:       return PS_TRIM;
            1:       return PS_BGAP;
            2:       return PS_REF;
            default: return PS_BYP;
        endcase
    endfunction

endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign sync_o = sh_q[STAGES-1];
endmodule

// File: rtl/pwrseq_stage_timer.sv
module pwrseq_stage_timer #(
    parameter int TMO_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic run_i,
    output logic expired_o
);
    localparam int CW = $clog2(TMO_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(TMO_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart_i)                 cnt_d = '0;
        else if (run_i && cnt_q != LAST) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = run_i && (cnt_q == LAST);

    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R8
endmodule

// File: rtl/pwrseq_chan_gate.sv
module pwrseq_chan_gate (
    input  logic run_next_i,
    input  logic en1_i,
    input  logic en2_i,
    input  logic ch1_on_q_i,
    input  logic ch1_ready_i,
    input  logic ch2_on_q_i,
    output logic ch1_on_d_o,
    output logic ch2_on_d_o
);
    logic ch2_may_start;

    always_comb begin
        ch2_may_start = !en1_i || (ch1_on_q_i && ch1_ready_i);
        ch1_on_d_o    = run_next_i && en1_i;
        ch2_on_d_o    = run_next_i && en2_i && (ch2_on_q_i || ch2_may_start);
    end
endmodule

// File: rtl/pwrseq_dual.sv
module pwrseq_dual
    import pwrseq_pkg::*;
#(
    parameter int TMO_CYC   = 16,
    parameter int SYNC_FLOP = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ch1_en_i,
    input  logic ch2_en_i,
    input  logic uv_ok_i,
    input  logic trim_done_i,
    input  logic bgap_done_i,
    input  logic ref_done_i,
    input  logic byp_done_i,
    input  logic ch1_at_target_i,
    output logic trim_start_o,
    output logic bgap_start_o,
    output logic ref_start_o,
    output logic byp_start_o,
    output logic ch1_on_o,
    output logic ch2_on_o,
    output logic fault_o
);
    seq_regs_t r_d, r_q;

    logic               uv_s;
    logic               any_en;
    logic               in_stage;
    logic               stage_done;
    logic               expired;
    logic               timeout;
    logic               ch1_d, ch2_d;
    pwr_state_e         stage_next;
    logic [N_STAGE-1:0] done_vec;

    assign done_vec = {byp_done_i, ref_done_i, bgap_done_i, trim_done_i};
    assign any_en   = ch1_en_i || ch2_en_i;

    pwrseq_sync #(.STAGES(SYNC_FLOP)) u_uv_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(uv_ok_i),
        .sync_o (uv_s)
    );

    pwrseq_stage_timer #(.TMO_CYC(TMO_CYC)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart_i(r_d.state != r_q.state),
        .run_i    (in_stage),
        .expired_o(expired)
    );

    pwrseq_chan_gate u_gate (
        .run_next_i (r_d.state == PS_RUN),
        .en1_i      (ch1_en_i),
        .en2_i      (ch2_en_i),
        .ch1_on_q_i (r_q.ch1_on),
        .ch1_ready_i(ch1_at_target_i),
        .ch2_on_q_i (r_q.ch2_on),
        .ch1_on_d_o (ch1_d),
        .ch2_on_d_o (ch2_d)
    );

    always_comb begin
        in_stage   = 1'b0;
        stage_done = 1'b0;
        stage_next = PS_RUN;
        for (int i = 0; i < N_STAGE; i++) begin
            if (r_q.state == stage_of(i)) begin
                in_stage   = 1'b1;
                stage_done = done_vec[i];
                stage_next = (i == N_STAGE - 1) ? PS_RUN : stage_of(i + 1);
            end
        end
        timeout = in_stage && any_en && uv_s && !stage_done && expired;
    end

    always_comb begin
        r_d = r_q;
        if (r_q.state == PS_OFF) begin
            if (any_en && !r_q.blocked) r_d.state = PS_WAIT_UV;
        end else if (!any_en) begin
            r_d.state = PS_OFF;
        end else if (r_q.state == PS_WAIT_UV) begin
            if (uv_s) r_d.state = PS_TRIM;
        end else if (!uv_s) begin
            r_d.state = PS_WAIT_UV;
        end else if (in_stage) begin
            if (stage_done)   r_d.state = stage_next;
            else if (timeout) r_d.state = PS_OFF;
        end
        for (int i = 0; i < N_STAGE; i++) begin
            r_d.strobe[i] = (r_d.state == stage_of(i)) && (r_q.state != stage_of(i));
        end
        r_d.ch1_on  = ch1_d;
        r_d.ch2_on  = ch2_d;
        r_d.fault   = r_q.fault || timeout;
        r_d.blocked = timeout || (r_q.blocked && any_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: PS_OFF, default: '0};
        else        r_q <= r_d;
    end

    assign trim_start_o = r_q.strobe[0];
    assign bgap_start_o = r_q.strobe[1];
    assign ref_start_o  = r_q.strobe[2];
    assign byp_start_o  = r_q.strobe[3];
    assign ch1_on_o     = r_q.ch1_on;
    assign ch2_on_o     = r_q.ch2_on;
    assign fault_o      = r_q.fault;

    AST_SHUTDOWN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!ch1_en_i && !ch2_en_i) |=> (!ch1_on_o && !ch2_on_o)); // R1
    AST_TRIM_NEEDS_UV: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trim_start_o) |-> $past(uv_s)); // R2
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({trim_start_o, bgap_start_o, ref_start_o, byp_start_o})); // R3
    AST_CH2_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ch2_on_o) |-> $past(!ch1_en_i || (ch1_on_o && ch1_at_target_i))); // R4
    AST_UV_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !uv_s |=> (!ch1_on_o && !ch2_on_o)); // R7
    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |=> fault_o); // R8
endmodule

// File: tb/pwrseq_dual_tb.sv
module pwrseq_dual_tb;
    localparam int TMO = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en1 = 0, en2 = 0, uv = 0;
    logic [3:0] dn = 4'b0000;
    logic rdy1 = 0;
    logic s_trim, s_bg, s_ref, s_byp, c1, c2, flt;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    pwrseq_dual #(.TMO_CYC(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .ch1_en_i(en1), .ch2_en_i(en2), .uv_ok_i(uv),
        .trim_done_i(dn[0]), .bgap_done_i(dn[1]), .ref_done_i(dn[2]), .byp_done_i(dn[3]),
        .ch1_at_target_i(rdy1),
        .trim_start_o(s_trim), .bgap_start_o(s_bg), .ref_start_o(s_ref), .byp_start_o(s_byp),
        .ch1_on_o(c1), .ch2_on_o(c2), .fault_o(flt)
    );

    // behavioural reference: phase 0 off, 1 waiting supply, 2..5 stages, 6 running
    int   m_ph = 0, m_wait = 0;
    logic m_uv1 = 0, m_uv2 = 0, m_blk = 0, m_flt = 0, m_c1 = 0, m_c2 = 0;
    logic [3:0] m_str = 0;

    always @(posedge clk) begin
        int  np;
        logic tmo, anyr;
        if (!rst_n) begin
            m_ph = 0; m_wait = 0; m_uv1 = 0; m_uv2 = 0; m_blk = 0;
            m_flt = 0; m_c1 = 0; m_c2 = 0; m_str = 0;
        end else begin
            anyr = en1 | en2;
            np = m_ph;
            tmo = 0;
            if (m_ph == 0)              np = (anyr && !m_blk) ? 1 : 0;
            else if (!anyr)             np = 0;
            else if (m_ph == 1)         np = m_uv2 ? 2 : 1;
            else if (!m_uv2)            np = 1;
            else if (m_ph < 6) begin
                if (dn[m_ph-2])           np = m_ph + 1;
                else if (m_wait == TMO-1) begin np = 0; tmo = 1; end
            end
            m_str = (np >= 2 && np <= 5 && np != m_ph) ? 4'(1 << (np - 2)) : 4'b0;
            m_c2  = (np == 6) && en2 && (m_c2 || !en1 || (m_c1 && rdy1));
            m_c1  = (np == 6) && en1;
            if (np != m_ph) m_wait = 0;
            else if (m_ph >= 2 && m_ph <= 5 && m_wait != TMO-1) m_wait++;
            m_blk = tmo | (m_blk & anyr);
            m_flt = m_flt | tmo;
            m_uv2 = m_uv1;
            m_uv1 = uv;
            m_ph  = np;
        end
    end

    always @(negedge clk) begin
        checks++;
        if ({s_byp, s_ref, s_bg, s_trim} !== m_str) begin
            failures++;
            $display("FAIL R3 strobes actual=%b expected=%b t=%0t", {s_byp, s_ref, s_bg, s_trim}, m_str, $time);
        end
        checks++;
        if ({c1, c2} !== {m_c1, m_c2}) begin
            failures++;
            $display("FAIL R4 channels actual=%b expected=%b t=%0t", {c1, c2}, {m_c1, m_c2}, $time);
        end
        checks++;
        if (flt !== m_flt) begin
            failures++;
            $display("FAIL R8 fault actual=%b expected=%b t=%0t", flt, m_flt, $time);
        end
    end

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        chk(c1 | c2 | s_trim | s_bg | s_ref | s_byp | flt, 1'b0, "R1 reset quiet");

        // R2: supply low holds the sequence
        en1 = 1; step(5);
        chk(s_trim, 1'b0, "R2 no trim while supply low");
        uv = 1; step(2);
        chk(s_trim, 1'b0, "R2 sync latency");
        step(1);
        chk(s_trim, 1'b1, "R2 trim after supply ok");
        // R3: ordered stages
        step(2);
        chk(s_bg, 1'b0, "R3 bandgap waits trim done");
        dn[0] = 1; step(1);
        chk(s_bg, 1'b1, "R3 bandgap strobe");
        chk(s_trim, 1'b0, "R3 trim strobe single cycle");
        dn = 4'b1111; step(1);
        chk(s_ref, 1'b1, "R3 reference strobe");
        step(1);
        chk(s_byp, 1'b1, "R3 bypass strobe");
        chk(c1, 1'b0, "R3 channel off before bypass done");
        step(1);
        chk(c1, 1'b1, "R3 channel 1 on after stages");
        // R4: channel 2 waits for target
        en2 = 1; step(4);
        chk(c2, 1'b0, "R4 channel 2 waits target");
        rdy1 = 1; step(1);
        chk(c2, 1'b1, "R4 channel 2 starts on target");
        // R9: single channel off
        en1 = 0; step(1);
        chk(c1, 1'b0, "R9 channel 1 off");
        chk(c2, 1'b1, "R9 channel 2 stays");
        chk(s_trim, 1'b0, "R9 no restart strobe");
        // R6: late channel 1 served at once
        rdy1 = 0; en1 = 1; step(1);
        chk(c1, 1'b1, "R6 channel 1 immediate");
        chk(c2, 1'b1, "R6 channel 2 unaffected");
        // R7: dropout and restart
        rdy1 = 1; uv = 0; step(2);
        chk(c1, 1'b1, "R7 before sync delay");
        step(1);
        chk(c1 | c2, 1'b0, "R7 both off on dropout");
        uv = 1; step(3);
        chk(s_trim, 1'b1, "R7 restart from trim");
        step(4);
        chk(c1, 1'b1, "R7 channel 1 after restart");
        chk(c2, 1'b0, "R7 channel 2 after channel 1");
        step(1);
        chk(c2, 1'b1, "R7 channel 2 resumes");
        // R1: shutdown
        en1 = 0; en2 = 0; step(1);
        chk(c1 | c2, 1'b0, "R1 shutdown");
        // R5: simultaneous enables
        rdy1 = 0; en1 = 1; en2 = 1; step(6);
        chk(c1, 1'b1, "R5 channel 1 first");
        chk(c2, 1'b0, "R5 channel 2 held");
        step(4);
        chk(c2, 1'b0, "R5 channel 2 still held");
        rdy1 = 1; step(1);
        chk(c2, 1'b1, "R5 channel 2 after target");
        en1 = 0; en2 = 0; step(2);
        // R5: channel 2 first, channel 1 during stages
        rdy1 = 0; en2 = 1; step(2);
        en1 = 1; step(4);
        chk(c1, 1'b1, "R5 late channel 1 takes priority");
        chk(c2, 1'b0, "R5 channel 2 deferred");
        en1 = 0; en2 = 0; step(2);
        // R4: channel 2 alone
        en2 = 1; step(6);
        chk(c2, 1'b1, "R4 channel 2 alone");
        en2 = 0; step(2);
        // R8: timeout
        dn[3] = 0; en1 = 1; step(5 + TMO - 1);
        chk(flt, 1'b0, "R8 no fault before limit");
        step(1);
        chk(flt, 1'b1, "R8 fault at limit");
        dn[3] = 1; step(10);
        chk(c1 | s_trim, 1'b0, "R8 no restart while held");
        en1 = 0; step(1);
        en1 = 1; step(6);
        chk(c1, 1'b1, "R8 restart after release");
        chk(flt, 1'b1, "R8 fault sticky");
        step(3);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule